// File: doc/BRIEF.md
# GPIO controller with interrupt routing

This block manages sixteen general-purpose pins. Each pin is set up as a plain input, an open-drain output or a push-pull output. It presents the tri-state controls (driven value and output enable) to pad logic outside the block. A per-pin output latch is used in one of two ways. In push-pull mode it supplies the driven value. In open-drain mode it supplies the output enable, and the driven value stays low. Every pin is sampled through a two-flop synchronizer. The synchronized values are readable in every mode.

Any pin can raise an event on a rising edge, a falling edge, or a high or low level. Edge events are latched in a status bit that software clears by writing a one to it. Level events show in the status only while the level holds. Each of the four interrupt lines is the OR of the enabled pin events routed to it. The routing is given by one 16-bit word per line, so each pin can reach any subset of the four lines. Software reaches all settings through 32-bit word registers, using single-cycle write and read strobes.

Top module: `gpio_irq_router`

## Requirements
- R1: Synchronous reset clears every register: all pins are inputs, the latches are 0, triggers are disabled and the status is clear. After reset, pin_oe, pin_out and irq are 0, and every address reads 0 while the pins are low.
- R2: A pin whose mode field is 2'b10 (push-pull) drives pin_out from its latch bit with pin_oe at 1. The mode register is at address 0, and pin p uses bits [2p+1:2p].
- R3: A pin whose mode field is 2'b01 (open-drain) keeps pin_out at 0 and drives pin_oe with the inverse of its latch bit. The latch register is at address 1, bit p. A latch of 0 pulls the pin low and a latch of 1 releases it.
- R4: A pin whose mode field is 2'b00 (input) or 2'b11 (treated as input) has pin_oe and pin_out at 0.
- R5: Address 2 returns pin_in in bits [15:0] after a two-flop synchronizer, in any mode. A read whose strobe falls in the clock period that follows a pin change still returns the old value. The read after it returns the new value.
- R6: A pin with trigger bit 0 (address 3, edge) sets its status bit (address 6, bit p) on a rising edge when its polarity bit (address 4) is 1, and on a falling edge when it is 0. The opposite edge does not set the bit. A set bit stays set.
- R7: Writing address 6 clears the status bits written as 1 and leaves the bits written as 0 unchanged.
- R8: A pin with trigger bit 1 (level) shows status 1 exactly while its synchronized value equals its polarity bit. The bit drops by itself when the level goes away.
- R9: A pin whose enable bit (address 5, bit p) is 0 sets no status bit and contributes to no interrupt line.
- R10: irq[k] is 1 when any enabled pin p has its event active and bit p of the routing word for line k is set. The routing words are at addresses 8+k, for k = 0 to 3.
- R11: A read strobe returns the addressed register on rd_data one cycle later. Bits above the 16 pin bits read 0, except in the mode word. Addresses 7 and 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Value to drive on each pin |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 4 | Interrupt lines |

## Verification
The pad controls are checked in two ways. Every mode code is swept against several latch patterns with all pins in one mode. A mixed word then puts neighbouring pins in different modes, which would expose a field that decodes the wrong bit pair. Edge detection is run on every pin with both polarities, checking the status after each of the two edges, so swapped polarity or a cross-wired bit shows at once. Level triggering, enable masking and the clear-on-write path are tried with mixed patterns. Routing is swept by giving pin p the mask p mod 16 and raising one pin at a time, so every line-to-pin combination is seen.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OD  = 2'b01,
    PM_PP  = 2'b10,
    PM_RSV = 2'b11
  } pin_mode_e;

  localparam int unsigned A_MODE   = 0;
  localparam int unsigned A_LATCH  = 1;
  localparam int unsigned A_INPUT  = 2;
  localparam int unsigned A_TRIG   = 3;
  localparam int unsigned A_POL    = 4;
  localparam int unsigned A_EN     = 5;
  localparam int unsigned A_STAT   = 6;
  localparam int unsigned A_ROUTE0 = 8;

endpackage

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NP = 16,
  parameter int unsigned NI = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NP-1:0]          pin_val,
  input  logic [NP-1:0]          status,
  output logic [2*NP-1:0]        mode_q,
  output logic [NP-1:0]          latch_q,
  output logic [NP-1:0]          trig_q,
  output logic [NP-1:0]          pol_q,
  output logic [NP-1:0]          en_q,
  output logic [NI-1:0][NP-1:0]  route_q,
  output logic [NP-1:0]          stat_clr,
  output logic [DW-1:0]          rd_data
);

  logic [DW-1:0] rd_mux;

  // configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      latch_q <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(A_MODE):  mode_q  <= wr_data[2*NP-1:0];
        AW'(A_LATCH): latch_q <= wr_data[NP-1:0];
        AW'(A_TRIG):  trig_q  <= wr_data[NP-1:0];
        AW'(A_POL):   pol_q   <= wr_data[NP-1:0];
        AW'(A_EN):    en_q    <= wr_data[NP-1:0];
        default: begin
          for (int k = 0; k < NI; k++) begin
            if (addr == AW'(A_ROUTE0 + k)) route_q[k] <= wr_data[NP-1:0];
          end
        end
      endcase
    end
  end

  // write-one-to-clear request for the status bits
  always_comb begin
    stat_clr = '0;
    if (wr_en && addr == AW'(A_STAT)) stat_clr = wr_data[NP-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(A_MODE):  rd_mux[2*NP-1:0] = mode_q;
      AW'(A_LATCH): rd_mux[NP-1:0]   = latch_q;
      AW'(A_INPUT): rd_mux[NP-1:0]   = pin_val;
      AW'(A_TRIG):  rd_mux[NP-1:0]   = trig_q;
      AW'(A_POL):   rd_mux[NP-1:0]   = pol_q;
      AW'(A_EN):    rd_mux[NP-1:0]   = en_q;
      AW'(A_STAT):  rd_mux[NP-1:0]   = status;
      default: begin
        for (int k = 0; k < NI; k++) begin
          if (addr == AW'(A_ROUTE0 + k)) rd_mux[NP-1:0] = route_q[k];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/gpio_irq_pads.sv
`timescale 1ns/1ps
module gpio_irq_pads
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NP = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*NP-1:0] mode_q,
  input  logic [NP-1:0]   latch_q,
  output logic [NP-1:0]   pin_out,
  output logic [NP-1:0]   pin_oe
);

  for (genvar g = 0; g < NP; g++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[g] <= 1'b0;
        pin_oe[g]  <= 1'b0;
      end else begin
        case (mode_q[2*g +: 2])
          PM_PP: begin
            pin_out[g] <= latch_q[g];
            pin_oe[g]  <= 1'b1;
          end
          PM_OD: begin
            pin_out[g] <= 1'b0;
            pin_oe[g]  <= ~latch_q[g];
          end
          default: begin
            pin_out[g] <= 1'b0;
            pin_oe[g]  <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int unsigned NP = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] pin_in,
  input  logic [NP-1:0] trig_q,
  input  logic [NP-1:0] pol_q,
  input  logic [NP-1:0] en_q,
  input  logic [NP-1:0] stat_clr,
  output logic [NP-1:0] pin_val,
  output logic [NP-1:0] evt
);

  logic [NP-1:0] meta, sync, prev, sticky;
  logic [NP-1:0] rise, fall, edge_set, level_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= pin_in;
      sync <= meta;
      prev <= sync;
    end
  end

  assign rise      = sync & ~prev;
  assign fall      = ~sync & prev;
  assign edge_set  = ((rise & pol_q) | (fall & ~pol_q)) & ~trig_q & en_q;
  assign level_hit = ~(sync ^ pol_q) & trig_q & en_q;

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) sticky <= '0;
    else     sticky <= (sticky & ~stat_clr) | edge_set;
  end

  assign pin_val = sync;
  assign evt     = sticky | level_hit;

endmodule

// File: rtl/gpio_irq_route.sv
`timescale 1ns/1ps
module gpio_irq_route #(
  parameter int unsigned NP = 16,
  parameter int unsigned NI = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         evt,
  input  logic [NP-1:0]         en_q,
  input  logic [NI-1:0][NP-1:0] route_q,
  output logic [NI-1:0]         irq
);

  logic [NP-1:0] live;
  assign live = evt & en_q;

  for (genvar k = 0; k < NI; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq[k] <= 1'b0;
      else     irq[k] <= |(live & route_q[k]);
    end
  end

endmodule

// File: rtl/gpio_irq_router.sv
`timescale 1ns/1ps
module gpio_irq_router #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned NIRQ  = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NIRQ-1:0]  irq
);

  logic [2*NPINS-1:0]          mode_q;
  logic [NPINS-1:0]            latch_q, trig_q, pol_q, en_q, stat_clr;
  logic [NPINS-1:0]            pin_val, evt;
  logic [NIRQ-1:0][NPINS-1:0]  route_q;

  gpio_irq_regs #(.NP(NPINS), .NI(NIRQ), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .pin_val(pin_val), .status(evt),
    .mode_q(mode_q), .latch_q(latch_q), .trig_q(trig_q), .pol_q(pol_q),
    .en_q(en_q), .route_q(route_q), .stat_clr(stat_clr), .rd_data(rd_data)
  );

  gpio_irq_pads #(.NP(NPINS)) u_pads (
    .clk(clk), .rst(rst), .mode_q(mode_q), .latch_q(latch_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_irq_detect #(.NP(NPINS)) u_detect (
    .clk(clk), .rst(rst), .pin_in(pin_in), .trig_q(trig_q), .pol_q(pol_q),
    .en_q(en_q), .stat_clr(stat_clr), .pin_val(pin_val), .evt(evt)
  );

  gpio_irq_route #(.NP(NPINS), .NI(NIRQ)) u_route (
    .clk(clk), .rst(rst), .evt(evt), .en_q(en_q), .route_q(route_q), .irq(irq)
  );

endmodule

// File: rtl/gpio_irq_router_chk.sv
`timescale 1ns/1ps
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NP = 16,
  parameter int unsigned NI = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NP-1:0]   pin_out,
  input logic [NP-1:0]   pin_oe,
  input logic [NI-1:0]   irq,
  input logic [2*NP-1:0] mode_q,
  input logic [NP-1:0]   trig_q,
  input logic [NP-1:0]   en_q,
  input logic [NP-1:0]   evt,
  input logic [NP-1:0]   stat_clr
);

  logic [NP-1:0] od_mask, pp_mask, in_mask;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      od_mask[p] = (mode_q[2*p +: 2] == PM_OD);
      pp_mask[p] = (mode_q[2*p +: 2] == PM_PP);
      in_mask[p] = (mode_q[2*p +: 2] == PM_IN) || (mode_q[2*p +: 2] == PM_RSV);
    end
  end

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pp_mask) & ~pin_oe) == '0)); // R2

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(od_mask) & pin_oe & pin_out) == '0)); // R3

  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(in_mask) & (pin_oe | pin_out)) == '0)); // R4

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stat_clr == '0) |=> (!$stable(trig_q) ||
      (((evt & ~trig_q) & $past(evt & ~trig_q)) == $past(evt & ~trig_q)))); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (irq == '0)); // R9

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    ((evt & en_q) == '0) |=> (irq == '0)); // R10

endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NP(NPINS), .NI(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .mode_q(mode_q), .trig_q(trig_q), .en_q(en_q), .evt(evt), .stat_clr(stat_clr)
);

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;

  localparam logic [3:0] AD_MODE = 4'd0, AD_LATCH = 4'd1, AD_INPUT = 4'd2,
                         AD_TRIG = 4'd3, AD_POL = 4'd4, AD_EN = 4'd5,
                         AD_STAT = 4'd6, AD_ROUTE = 4'd8;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  logic [3:0]  irq;
  int checks = 0, errors = 0;

  gpio_irq_router uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1 rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0; d = rd_data;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] exp_out(input logic [31:0] mw, input logic [15:0] lat);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) r[p] = (mw[2*p +: 2] == 2'b10) ? lat[p] : 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] exp_oe(input logic [31:0] mw, input logic [15:0] lat);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) begin
      if (mw[2*p +: 2] == 2'b10)      r[p] = 1'b1;
      else if (mw[2*p +: 2] == 2'b01) r[p] = ~lat[p];
      else                            r[p] = 1'b0;
    end
    return r;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, mw;
    logic [15:0] lat [4];
    logic [15:0] pats [4];
    lat[0] = 16'h0000; lat[1] = 16'hFFFF; lat[2] = 16'hA5C3; lat[3] = 16'h5A3C;
    pats[0] = 16'h0001; pats[1] = 16'h8000; pats[2] = 16'hC35A; pats[3] = 16'h3CA5;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 addr %0d", a), d, 32'h0);
    end

    // R11 readback
    wr(AD_MODE, 32'hA5A5_3C3C);   rd(AD_MODE, d);  chk("R11 mode", d, 32'hA5A5_3C3C);
    wr(AD_LATCH, 32'hFFFF_1234);  rd(AD_LATCH, d); chk("R11 latch", d, 32'h0000_1234);
    wr(AD_TRIG, 32'h0F0F_8001);   rd(AD_TRIG, d);  chk("R11 trig", d, 32'h0000_8001);
    wr(AD_POL, 32'h1111_2468);    rd(AD_POL, d);   chk("R11 pol", d, 32'h0000_2468);
    for (int k = 0; k < 4; k++) begin
      wr(AD_ROUTE + 4'(k), 32'hFF00_0000 | (32'h0101 << k));
      rd(AD_ROUTE + 4'(k), d);
      chk($sformatf("R11 route %0d", k), d, 32'h0101 << k);
    end
    wr(AD_EN, 32'hFFFF_0000);     rd(AD_EN, d);    chk("R11 en", d, 32'h0);
    rd(4'd7, d);  chk("R11 addr 7", d, 32'h0);
    rd(4'd12, d); chk("R11 addr 12", d, 32'h0);
    wr(AD_MODE, 0); wr(AD_LATCH, 0); wr(AD_TRIG, 0); wr(AD_POL, 0);

    // R2 R3 R4 mode sweep
    for (int m = 0; m < 4; m++) begin
      mw = {16{m[1:0]}};
      wr(AD_MODE, mw);
      for (int i = 0; i < 4; i++) begin
        wr(AD_LATCH, {16'h0, lat[i]});
        settle();
        chk(m == 2 ? "R2 out" : (m == 1 ? "R3 out" : "R4 out"),
            {16'h0, pin_out}, {16'h0, exp_out(mw, lat[i])});
        chk(m == 2 ? "R2 oe" : (m == 1 ? "R3 oe" : "R4 oe"),
            {16'h0, pin_oe}, {16'h0, exp_oe(mw, lat[i])});
      end
    end
    mw = 32'h1B1B_E4E4;
    wr(AD_MODE, mw);
    for (int i = 0; i < 4; i++) begin
      wr(AD_LATCH, {16'h0, lat[i]});
      settle();
      chk("R2 R3 R4 mixed out", {16'h0, pin_out}, {16'h0, exp_out(mw, lat[i])});
      chk("R2 R3 R4 mixed oe", {16'h0, pin_oe}, {16'h0, exp_oe(mw, lat[i])});
    end

    // R5 input register in push-pull mode, then latency
    wr(AD_MODE, 32'hAAAA_AAAA);
    for (int i = 0; i < 4; i++) begin
      pin_in = pats[i];
      settle();
      rd(AD_INPUT, d);
      chk("R5 input", d, {16'h0, pats[i]});
    end
    pin_in = 16'h0F0F;
    rd(AD_INPUT, d); chk("R5 sync old", d, {16'h0, pats[3]});
    rd(AD_INPUT, d); chk("R5 sync new", d, 32'h0000_0F0F);
    wr(AD_MODE, 0); wr(AD_LATCH, 0);
    pin_in = '0;
    settle();

    // R6 R7 edge sweep, all pins routed to all lines
    for (int k = 0; k < 4; k++) wr(AD_ROUTE + 4'(k), 32'hFFFF);
    wr(AD_TRIG, 0);
    for (int p = 0; p < 16; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [15:0] b;
        b = 16'h1 << p;
        wr(AD_POL, pol == 1 ? {16'h0, b} : 32'h0);
        wr(AD_EN, {16'h0, b});
        wr(AD_STAT, 32'hFFFF);
        settle();
        rd(AD_STAT, d); chk("R6 idle", d, 32'h0);
        pin_in = b;
        settle();
        rd(AD_STAT, d); chk("R6 after rise", d, pol == 1 ? {16'h0, b} : 32'h0);
        chk("R6 irq after rise", {28'h0, irq}, pol == 1 ? 32'hF : 32'h0);
        pin_in = '0;
        settle();
        rd(AD_STAT, d); chk("R6 after fall", d, {16'h0, b});
        wr(AD_STAT, 0);
        rd(AD_STAT, d); chk("R7 zero write", d, {16'h0, b});
        wr(AD_STAT, {16'h0, ~b});
        rd(AD_STAT, d); chk("R7 other bits", d, {16'h0, b});
        wr(AD_STAT, {16'h0, b});
        rd(AD_STAT, d); chk("R7 cleared", d, 32'h0);
        settle();
        chk("R7 irq cleared", {28'h0, irq}, 32'h0);
      end
    end

    // R8 level trigger
    wr(AD_TRIG, 32'hFFFF);
    wr(AD_POL, 32'h00FF);
    wr(AD_EN, 32'hFFFF);
    wr(AD_STAT, 32'hFFFF);
    for (int i = 0; i < 4; i++) begin
      pin_in = pats[i];
      settle();
      rd(AD_STAT, d);
      chk("R8 level", d, {16'h0, ~(pats[i] ^ 16'h00FF)});
    end
    pin_in = 16'h00FF;
    settle();
    rd(AD_STAT, d); chk("R8 level all high", d, 32'hFFFF);
    pin_in = 16'hFF00;
    settle();
    rd(AD_STAT, d); chk("R8 level gone", d, 32'h0);
    chk("R8 irq gone", {28'h0, irq}, 32'h0);

    // R9 enable mask
    pin_in = '0;
    wr(AD_TRIG, 0); wr(AD_POL, 32'hFFFF); wr(AD_EN, 32'h00FF);
    settle();
    wr(AD_STAT, 32'hFFFF);
    pin_in = 16'hFFFF;
    settle();
    rd(AD_STAT, d); chk("R9 partial enable", d, 32'h00FF);
    chk("R9 irq partial", {28'h0, irq}, 32'hF);
    wr(AD_EN, 0);
    wr(AD_STAT, 32'hFFFF);
    pin_in = '0;
    settle();
    pin_in = 16'hFFFF;
    settle();
    rd(AD_STAT, d); chk("R9 disabled status", d, 32'h0);
    chk("R9 disabled irq", {28'h0, irq}, 32'h0);
    pin_in = '0;
    wr(AD_TRIG, 32'hFFFF); wr(AD_POL, 0);
    settle();
    rd(AD_STAT, d); chk("R9 disabled level", d, 32'h0);
    chk("R9 disabled level irq", {28'h0, irq}, 32'h0);

    // R10 routing sweep: pin p carries mask p mod 16
    for (int k = 0; k < 4; k++) begin
      logic [15:0] rw = '0;
      for (int p = 0; p < 16; p++) rw[p] = p[k];
      wr(AD_ROUTE + 4'(k), {16'h0, rw});
    end
    wr(AD_TRIG, 32'hFFFF); wr(AD_POL, 32'hFFFF); wr(AD_EN, 32'hFFFF);
    pin_in = '0;
    settle();
    chk("R10 quiet", {28'h0, irq}, 32'h0);
    for (int p = 0; p < 16; p++) begin
      pin_in = 16'h1 << p;
      settle();
      chk($sformatf("R10 pin %0d", p), {28'h0, irq}, 32'(p[3:0]));
    end
    pin_in = 16'h0018;
    settle();
    chk("R10 two pins", {28'h0, irq}, 32'h7);
    pin_in = 16'hFFFF;
    wr(AD_EN, 32'h0020);
    settle();
    chk("R10 enable gates", {28'h0, irq}, 32'h5);

    finish_run();
  end

endmodule